// File: doc/BRIEF.md
# Product Term Allocator Chain

This block is the sum-of-products core of one programmable logic function block. A configurable AND array forms product terms over the true and inverted forms of the data inputs. The terms are grouped five to a cell. Each cell has an allocator that decides where its five terms go. A term can stay in the cell's own sum, or it can be exported into a partial sum that travels to a neighbouring cell. Partial sums can pass through several cells, in either direction, so one cell can gather many more than five terms. The final result is one OR sum per cell.

For each cell the block also reports a logic span. The span is the number of allocator stages that the longest accepted chain has passed through before it reaches that cell. It is the figure a timing model multiplies by the per-stage allocator delay. A cell that uses only its own terms has span 0.

The AND masks and the allocator settings are held in configuration registers, written one word per clock. The sums follow the data inputs combinationally. A configuration that loses terms, leaves an import with no source, or sends terms off the end of the chain raises an error flag.

Top module: `pta_chain`

## Requirements
- R1: A product term is 1 only when it selects at least one literal and every selected literal is true. In a term's mask word, bit k (k < N_IN) selects input k and bit N_IN+k selects the inverse of input k. An empty mask gives 0, and so does a mask that selects both forms of one input.
- R2: After reset, every mask is clear and every cell keeps all five terms and neither sends nor imports. So every sum is 0, every span is 0 and the error flag is 0.
- R3: A term whose keep bit is 1 is ORed into its home cell's sum. In a cell that sends, a term whose keep bit is 0 does not reach the home sum. Cell word bits [4:0] are the keep bits for terms 0..4 of the cell.
- R4: A cell with send code 01 passes its exported terms to the next higher cell. A higher cell whose import-from-below bit (bit 5) is set and whose send code is 00 ORs that partial sum into its own sum.
- R5: A cell with send code 10 passes its exported terms to the next lower cell. A lower cell whose import-from-above bit (bit 6) is set and whose send code is 00 ORs that partial sum into its own sum.
- R6: A sending cell that also imports in the direction of travel forwards the incoming partial sum together with its own exported terms. Chains may therefore span any number of cells.
- R7: A cell with send code 00 reports as its span the number of allocator stages in the longest chain it accepts, or 0 when it accepts none. A sending cell reports span 0. Cell c's span is span_out[4c+3:4c].
- R8: The error flag is 1 when any of these holds: a cell imports from a neighbour that does not send toward it; a neighbour sends toward a cell that does not import it; the top cell sends up or cell 0 sends down; a cell imports against its own send direction.
- R9: A write to address t < 5*N_CELL loads term t's mask. A write to address 5*N_CELL+c loads cell c's word (bits [8:0]). Outputs reflect a write from the clock edge that accepts it, and not before. Writes to higher addresses change nothing.
- R10: Send code 11 is reserved. A cell with that code sums like code 00 and raises the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(6*N_CELL) | Configuration word address |
| cfg_wdata | input | 2*N_IN | Configuration write data |
| data_in | input | N_IN | Function block inputs |
| sum_out | output | N_CELL | One OR sum per cell |
| span_out | output | 4*N_CELL | Logic span per cell, 4 bits each |
| cfg_err | output | 1 | Inconsistent allocator configuration |

## Verification
The bench aims at the cases where steering is easy to get wrong. An exported term that leaks into its home sum shows up as a cell that stays high after giving its terms away. A chain that drops the forwarded partial sum shows up as a destination that is low when the far end term is true. A span counter that is off by one reports 3 or 5 instead of 4 at the end of a four-stage chain. Contradictory masks, the reserved send code, sends off either end of the chain, and the write-edge timing are driven directly. A design that gets any of these wrong gives a sum that is stuck at one value, a span that is off by one, or an error flag that is silent.

// File: rtl/pta_pkg.sv
package pta_pkg;

   localparam int TERMS_PER_CELL = 5;
   localparam int CELL_CFG_W     = 9;

   typedef enum logic [1:0] {
      SEND_NONE = 2'b00,
      SEND_UP   = 2'b01,
      SEND_DOWN = 2'b10,
      SEND_RSVD = 2'b11
   } send_e;

   // bit layout: [8:7] send, [6] import from above, [5] import from below, [4:0] keep
   typedef struct packed {
      send_e                     send;
      logic                      take_up;
      logic                      take_dn;
      logic [TERMS_PER_CELL-1:0] keep;
   } cell_cfg_t;

   localparam cell_cfg_t CELL_CFG_RST = '{send: SEND_NONE, take_up: 1'b0,
                                          take_dn: 1'b0, keep: '1};

endpackage

// File: rtl/pta_cfg_store.sv
module pta_cfg_store
   import pta_pkg::*;
#(
   parameter  int N_IN   = 12,
   parameter  int N_CELL = 8,
   localparam int NT     = N_CELL * TERMS_PER_CELL,
   localparam int LW     = 2 * N_IN,
   localparam int AW     = $clog2(NT + N_CELL)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [AW-1:0]                cfg_addr,
   input  logic [LW-1:0]                cfg_wdata,
   output logic [NT*LW-1:0]             term_mask,
   output logic [N_CELL*CELL_CFG_W-1:0] cell_cfg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         term_mask <= '0;
      end else if (cfg_we) begin
         for (int t = 0; t < NT; t++) begin
            if (cfg_addr == AW'(t)) term_mask[t*LW +: LW] <= cfg_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < N_CELL; c++) cell_cfg[c*CELL_CFG_W +: CELL_CFG_W] <= CELL_CFG_RST;
      end else if (cfg_we) begin
         for (int c = 0; c < N_CELL; c++) begin
            if (cfg_addr == AW'(NT + c))
               cell_cfg[c*CELL_CFG_W +: CELL_CFG_W] <= cfg_wdata[CELL_CFG_W-1:0];
         end
      end
   end

   for (genvar c = 0; c < N_CELL; c++) begin : g_chk
      // R9
      cell_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_addr == AW'(NT + c)) |=>
            cell_cfg[c*CELL_CFG_W +: CELL_CFG_W] == $past(cfg_wdata[CELL_CFG_W-1:0]));
      // R2
      cell_rst_chk: assert property (@(posedge clk)
         !rst_n |=> (!rst_n || cell_cfg[c*CELL_CFG_W +: CELL_CFG_W] == CELL_CFG_RST));
   end

endmodule

// File: rtl/pta_and_array.sv
module pta_and_array
   import pta_pkg::*;
#(
   parameter  int N_IN   = 12,
   parameter  int N_CELL = 8,
   localparam int NT     = N_CELL * TERMS_PER_CELL,
   localparam int LW     = 2 * N_IN
) (
   input  logic [N_IN-1:0]  data_in,
   input  logic [NT*LW-1:0] term_mask,
   output logic [NT-1:0]    terms
);

   // literal vector: true forms low, inverted forms high
   logic [LW-1:0] literals;
   assign literals = {~data_in, data_in};

   for (genvar t = 0; t < NT; t++) begin : g_term
      logic [LW-1:0] m;
      assign m        = term_mask[t*LW +: LW];
      assign terms[t] = (|m) & (&(literals | ~m));
   end

endmodule

// File: rtl/pta_alloc_cell.sv
module pta_alloc_cell
   import pta_pkg::*;
#(
   parameter int SPAN_W = 4
) (
   input  cell_cfg_t                 cfg,
   input  logic [TERMS_PER_CELL-1:0] terms,
   input  logic                      up_in_vld,
   input  logic                      up_in,
   input  logic [SPAN_W-1:0]         up_in_span,
   input  logic                      dn_in_vld,
   input  logic                      dn_in,
   input  logic [SPAN_W-1:0]         dn_in_span,
   output logic                      up_out_vld,
   output logic                      up_out,
   output logic [SPAN_W-1:0]         up_out_span,
   output logic                      dn_out_vld,
   output logic                      dn_out,
   output logic [SPAN_W-1:0]         dn_out_span,
   output logic                      sum,
   output logic [SPAN_W-1:0]         span,
   output logic                      err
);

   logic kept, expo, acc_up, acc_dn, from_below, from_above;
   logic [SPAN_W-1:0] sp_below, sp_above;

   assign kept       = |(terms & cfg.keep);
   assign expo       = |(terms & ~cfg.keep);
   assign acc_up     = cfg.take_dn & up_in_vld;
   assign acc_dn     = cfg.take_up & dn_in_vld;
   assign from_below = acc_up & up_in;
   assign from_above = acc_dn & dn_in;
   assign sp_below   = acc_up ? up_in_span : '0;
   assign sp_above   = acc_dn ? dn_in_span : '0;

   always_comb begin
      up_out_vld  = 1'b0;
      up_out      = 1'b0;
      up_out_span = '0;
      dn_out_vld  = 1'b0;
      dn_out      = 1'b0;
      dn_out_span = '0;
      sum         = kept;
      span        = '0;
      case (cfg.send)
         SEND_UP: begin
            up_out_vld  = 1'b1;
            up_out      = expo | from_below;
            up_out_span = sp_below + SPAN_W'(1);
         end
         SEND_DOWN: begin
            dn_out_vld  = 1'b1;
            dn_out      = expo | from_above;
            dn_out_span = sp_above + SPAN_W'(1);
         end
         default: begin
            sum  = kept | expo | from_below | from_above;
            span = (sp_below > sp_above) ? sp_below : sp_above;
         end
      endcase
   end

   assign err = (cfg.send == SEND_RSVD)
              | ((cfg.send == SEND_UP) & cfg.take_up)
              | ((cfg.send == SEND_DOWN) & cfg.take_dn)
              | (cfg.take_dn ^ up_in_vld)
              | (cfg.take_up ^ dn_in_vld);

endmodule

// File: rtl/pta_chain.sv
module pta_chain
   import pta_pkg::*;
#(
   parameter  int N_IN   = 12,
   parameter  int N_CELL = 8,
   parameter  int SPAN_W = 4,
   localparam int NT     = N_CELL * TERMS_PER_CELL,
   localparam int LW     = 2 * N_IN,
   localparam int AW     = $clog2(NT + N_CELL)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [AW-1:0]            cfg_addr,
   input  logic [LW-1:0]            cfg_wdata,
   input  logic [N_IN-1:0]          data_in,
   output logic [N_CELL-1:0]        sum_out,
   output logic [N_CELL*SPAN_W-1:0] span_out,
   output logic                     cfg_err
);

   if (LW < CELL_CFG_W) begin : g_bad_width
      $error("pta_chain: 2*N_IN must hold a cell configuration word");
   end
   if (N_CELL < 2) begin : g_bad_cells
      $error("pta_chain: at least two cells are needed");
   end
   if (N_CELL > (1 << SPAN_W)) begin : g_bad_span
      $error("pta_chain: SPAN_W too narrow for the longest chain");
   end

   logic [NT*LW-1:0]             term_mask;
   logic [N_CELL*CELL_CFG_W-1:0] cell_cfg;
   logic [NT-1:0]                terms;

   logic [N_CELL-1:0]        up_v, up_d, dn_v, dn_d, errs;
   logic [N_CELL*SPAN_W-1:0] up_sp, dn_sp;

   pta_cfg_store #(.N_IN(N_IN), .N_CELL(N_CELL)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .term_mask (term_mask),
      .cell_cfg  (cell_cfg)
   );

   pta_and_array #(.N_IN(N_IN), .N_CELL(N_CELL)) u_and (
      .data_in   (data_in),
      .term_mask (term_mask),
      .terms     (terms)
   );

   for (genvar c = 0; c < N_CELL; c++) begin : g_cell
      cell_cfg_t         cfg_c;
      logic              ui_v, ui_d, di_v, di_d;
      logic [SPAN_W-1:0] ui_sp, di_sp;

      assign cfg_c = cell_cfg_t'(cell_cfg[c*CELL_CFG_W +: CELL_CFG_W]);

      if (c > 0) begin : g_below
         assign ui_v  = up_v[c-1];
         assign ui_d  = up_d[c-1];
         assign ui_sp = up_sp[(c-1)*SPAN_W +: SPAN_W];
      end else begin : g_floor
         assign ui_v  = 1'b0;
         assign ui_d  = 1'b0;
         assign ui_sp = '0;
      end

      if (c < N_CELL-1) begin : g_above
         assign di_v  = dn_v[c+1];
         assign di_d  = dn_d[c+1];
         assign di_sp = dn_sp[(c+1)*SPAN_W +: SPAN_W];
      end else begin : g_ceil
         assign di_v  = 1'b0;
         assign di_d  = 1'b0;
         assign di_sp = '0;
      end

      pta_alloc_cell #(.SPAN_W(SPAN_W)) u_cell (
         .cfg         (cfg_c),
         .terms       (terms[c*TERMS_PER_CELL +: TERMS_PER_CELL]),
         .up_in_vld   (ui_v),
         .up_in       (ui_d),
         .up_in_span  (ui_sp),
         .dn_in_vld   (di_v),
         .dn_in       (di_d),
         .dn_in_span  (di_sp),
         .up_out_vld  (up_v[c]),
         .up_out      (up_d[c]),
         .up_out_span (up_sp[c*SPAN_W +: SPAN_W]),
         .dn_out_vld  (dn_v[c]),
         .dn_out      (dn_d[c]),
         .dn_out_span (dn_sp[c*SPAN_W +: SPAN_W]),
         .sum         (sum_out[c]),
         .span        (span_out[c*SPAN_W +: SPAN_W]),
         .err         (errs[c])
      );

      // R3
      give_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((cfg_c.send == SEND_UP || cfg_c.send == SEND_DOWN) &&
          !(|(terms[c*TERMS_PER_CELL +: TERMS_PER_CELL] & cfg_c.keep))) |-> !sum_out[c]);

      // R7
      sender_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_c.send == SEND_UP || cfg_c.send == SEND_DOWN) |->
            span_out[c*SPAN_W +: SPAN_W] == '0);

      if (c < N_CELL-1) begin : g_pair_chk
         cell_cfg_t nxt;
         assign nxt = cell_cfg_t'(cell_cfg[(c+1)*CELL_CFG_W +: CELL_CFG_W]);
         // R4
         up_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_c.send == SEND_UP && nxt.take_dn && nxt.send == SEND_NONE &&
             |(terms[c*TERMS_PER_CELL +: TERMS_PER_CELL] & ~cfg_c.keep)) |-> sum_out[c+1]);
         // R8
         lost_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_c.send == SEND_UP && !nxt.take_dn) |-> cfg_err);
      end
   end

   assign cfg_err = (|errs) | up_v[N_CELL-1] | dn_v[0];

   // R8
   edge_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_cfg[(N_CELL-1)*CELL_CFG_W + 8 -: 2] == 2'b01 ||
       cell_cfg[8 -: 2] == 2'b10) |-> cfg_err);

endmodule

// File: tb/sim_pta_chain.sv
module sim_pta_chain;

   localparam int N_IN   = 6;
   localparam int N_CELL = 5;
   localparam int SPAN_W = 4;
   localparam int NT     = N_CELL * 5;
   localparam int LW     = 2 * N_IN;
   localparam int AW     = $clog2(NT + N_CELL);

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     cfg_we = 1'b0;
   logic [AW-1:0]            cfg_addr = '0;
   logic [LW-1:0]            cfg_wdata = '0;
   logic [N_IN-1:0]          data_in = '0;
   logic [N_CELL-1:0]        sum_out;
   logic [N_CELL*SPAN_W-1:0] span_out;
   logic                     cfg_err;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   pta_chain #(.N_IN(N_IN), .N_CELL(N_CELL), .SPAN_W(SPAN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .data_in(data_in), .sum_out(sum_out),
      .span_out(span_out), .cfg_err(cfg_err)
   );

   always #10 clk = ~clk;

   // shadow configuration
   logic [LW-1:0] m_mask [NT];
   logic [8:0]    m_cfg  [N_CELL];
   int            exp_sum  [N_CELL];
   int            exp_span [N_CELL];
   int            exp_err;

   function automatic logic [8:0] cw(int keep, int tdn, int tup, int snd);
      return {2'(snd), 1'(tup), 1'(tdn), 5'(keep)};
   endfunction

   function automatic int term_val(int t, logic [N_IN-1:0] d);
      logic [N_IN-1:0] lo, hi;
      lo = m_mask[t][N_IN-1:0];
      hi = m_mask[t][LW-1:N_IN];
      if (m_mask[t] == '0) return 0;
      return (((d & lo) == lo) && ((~d & hi) == hi)) ? 1 : 0;
   endfunction

   task automatic model(input logic [N_IN-1:0] d);
      int tv [NT];
      int uv [N_CELL], ud [N_CELL], us [N_CELL];
      int dv [N_CELL], dd [N_CELL], ds [N_CELL];
      int expo [N_CELL], kept [N_CELL];
      for (int t = 0; t < NT; t++) tv[t] = term_val(t, d);
      for (int c = 0; c < N_CELL; c++) begin
         kept[c] = 0; expo[c] = 0;
         for (int j = 0; j < 5; j++) begin
            if (tv[c*5+j] != 0 && m_cfg[c][j]) kept[c] = 1;
            if (tv[c*5+j] != 0 && !m_cfg[c][j]) expo[c] = 1;
         end
      end
      for (int c = 0; c < N_CELL; c++) begin
         int acc;
         acc = (m_cfg[c][5] && c > 0 && uv[c-1] != 0) ? 1 : 0;
         if (m_cfg[c][8:7] == 2'b01) begin
            uv[c] = 1;
            ud[c] = (expo[c] != 0 || (acc != 0 && ud[c-1] != 0)) ? 1 : 0;
            us[c] = (acc != 0) ? us[c-1] + 1 : 1;
         end else begin
            uv[c] = 0; ud[c] = 0; us[c] = 0;
         end
      end
      for (int c = N_CELL-1; c >= 0; c--) begin
         int acc;
         acc = (m_cfg[c][6] && c < N_CELL-1 && dv[c+1] != 0) ? 1 : 0;
         if (m_cfg[c][8:7] == 2'b10) begin
            dv[c] = 1;
            dd[c] = (expo[c] != 0 || (acc != 0 && dd[c+1] != 0)) ? 1 : 0;
            ds[c] = (acc != 0) ? ds[c+1] + 1 : 1;
         end else begin
            dv[c] = 0; dd[c] = 0; ds[c] = 0;
         end
      end
      exp_err = (uv[N_CELL-1] != 0 || dv[0] != 0) ? 1 : 0;
      for (int c = 0; c < N_CELL; c++) begin
         int in_up, in_dn, au, ad, snd;
         snd   = int'(m_cfg[c][8:7]);
         in_up = (c > 0) ? uv[c-1] : 0;
         in_dn = (c < N_CELL-1) ? dv[c+1] : 0;
         au    = (m_cfg[c][5] && in_up != 0) ? 1 : 0;
         ad    = (m_cfg[c][6] && in_dn != 0) ? 1 : 0;
         if (snd == 1 || snd == 2) begin
            exp_sum[c]  = kept[c];
            exp_span[c] = 0;
         end else begin
            exp_sum[c] = (kept[c] != 0 || expo[c] != 0 ||
                          (au != 0 && ud[c-1] != 0) || (ad != 0 && dd[c+1] != 0)) ? 1 : 0;
            exp_span[c] = 0;
            if (au != 0 && us[c-1] > exp_span[c]) exp_span[c] = us[c-1];
            if (ad != 0 && ds[c+1] > exp_span[c]) exp_span[c] = ds[c+1];
         end
         if (snd == 3) exp_err = 1;
         if (snd == 1 && m_cfg[c][6]) exp_err = 1;
         if (snd == 2 && m_cfg[c][5]) exp_err = 1;
         if (int'(m_cfg[c][5]) != in_up) exp_err = 1;
         if (int'(m_cfg[c][6]) != in_dn) exp_err = 1;
      end
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      model(data_in);
      for (int c = 0; c < N_CELL; c++) begin
         chk(req, $sformatf("sum[%0d]", c), int'(sum_out[c]), exp_sum[c]);
         chk(req, $sformatf("span[%0d]", c), int'(span_out[c*SPAN_W +: SPAN_W]), exp_span[c]);
      end
      chk(req, "err", int'(cfg_err), exp_err);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int t = 0; t < NT; t++) m_mask[t] = '0;
      for (int c = 0; c < N_CELL; c++) m_cfg[c] = cw(31, 0, 0, 0);
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [LW-1:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = AW'(a);
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < NT) m_mask[a] = v;
      else if (a < NT + N_CELL) m_cfg[a-NT] = v[8:0];
   endtask

   task automatic drive(input logic [N_IN-1:0] d);
      data_in = d;
      #1;
   endtask

   function automatic logic [LW-1:0] tmask(int tbit, int cbit);
      logic [LW-1:0] m;
      m = '0;
      if (tbit >= 0) m[tbit] = 1'b1;
      if (cbit >= 0) m[N_IN+cbit] = 1'b1;
      return m;
   endfunction

   initial begin
      #(20 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();

      // R2: reset state under several inputs
      for (int i = 0; i < 4; i++) begin
         drive(N_IN'($urandom(11 + i)));
         chk("R2", "sum after reset", int'(sum_out), 0);
         chk("R2", "span after reset", int'(span_out), 0);
         chk("R2", "err after reset", int'(cfg_err), 0);
      end

      // R1: term 0 = in0 & ~in1, cell 0 keeps it
      wr(0, tmask(0, 1));
      for (int d = 0; d < 4; d++) begin
         drive(N_IN'(d));
         chk("R1", "sum[0] true/inverted literal", int'(sum_out[0]), (d == 1) ? 1 : 0);
      end
      // R1: both forms of one input selected never fire
      wr(5, tmask(2, 2));
      for (int d = 0; d < 8; d++) begin
         drive(N_IN'(d << 1));
         chk("R1", "sum[1] contradictory term", int'(sum_out[1]), 0);
      end

      // R9: a write takes effect at its edge, not before
      drive(N_IN'(8));
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(10); cfg_wdata = tmask(3, -1);
      #1;
      chk("R9", "sum[2] before write edge", int'(sum_out[2]), 0);
      @(negedge clk);
      cfg_we = 1'b0;
      m_mask[10] = tmask(3, -1);
      #1;
      chk("R9", "sum[2] after write edge", int'(sum_out[2]), 1);
      // R9: out-of-range address changes nothing
      wr((1 << AW) - 1, '1);
      for (int d = 0; d < 16; d++) begin
         drive(N_IN'(d * 3));
         check_all("R9");
      end

      // R3 / R4: cell 0 exports term 0 upward, keeps term 1
      wr(1, tmask(4, -1));
      wr(NT + 0, cw(5'b11110, 0, 0, 1));
      wr(NT + 1, cw(31, 1, 0, 0));
      for (int d = 0; d < 32; d++) begin
         drive(N_IN'(d));
         chk("R3", "sum[0] keeps only kept terms", int'(sum_out[0]), ((d >> 4) & 1));
         chk("R4", "sum[1] receives exported term", int'(sum_out[1]), (d & 3) == 1 ? 1 : 0);
         chk("R7", "span[1] one stage", int'(span_out[SPAN_W +: SPAN_W]), 1);
         chk("R8", "consistent config no err", int'(cfg_err), 0);
      end

      // R6 / R7: four-stage upward chain into cell 4
      do_reset();
      wr(0, tmask(0, -1));
      wr(NT + 0, cw(5'b11110, 0, 0, 1));
      for (int c = 1; c < 4; c++) wr(NT + c, cw(31, 1, 0, 1));
      wr(NT + 4, cw(31, 1, 0, 0));
      drive(N_IN'(1));
      chk("R6", "sum[4] via chain", int'(sum_out[4]), 1);
      chk("R7", "span[4] four stages", int'(span_out[4*SPAN_W +: SPAN_W]), 4);
      chk("R7", "span[2] sender", int'(span_out[2*SPAN_W +: SPAN_W]), 0);
      chk("R8", "chain no err", int'(cfg_err), 0);
      drive(N_IN'(0));
      chk("R6", "sum[4] chain idle", int'(sum_out[4]), 0);

      // R5 / R7: four-stage downward chain into cell 0
      do_reset();
      wr(20, tmask(5, -1));
      wr(NT + 4, cw(5'b11110, 0, 0, 2));
      for (int c = 1; c < 4; c++) wr(NT + c, cw(31, 0, 1, 2));
      wr(NT + 0, cw(31, 0, 1, 0));
      drive(N_IN'(32));
      chk("R5", "sum[0] via down chain", int'(sum_out[0]), 1);
      chk("R5", "sum[4] gave term away", int'(sum_out[4]), 0);
      chk("R7", "span[0] four stages", int'(span_out[SPAN_W-1:0]), 4);
      check_all("R5");

      // R8: top cell sends up
      do_reset();
      wr(NT + 4, cw(31, 0, 0, 1));
      #1;
      chk("R8", "top sends up", int'(cfg_err), 1);
      // R8: dangling import
      do_reset();
      wr(NT + 1, cw(31, 1, 0, 0));
      #1;
      chk("R8", "import without sender", int'(cfg_err), 1);

      // R10: reserved send code sums like no-send and flags
      do_reset();
      wr(10, tmask(0, -1));
      wr(NT + 2, cw(5'b11110, 0, 0, 3));
      for (int d = 0; d < 2; d++) begin
         drive(N_IN'(d));
         chk("R10", "sum[2] reserved code", int'(sum_out[2]), d);
         chk("R10", "err reserved code", int'(cfg_err), 1);
      end

      // random configurations against the bench model
      do_reset();
      for (int it = 0; it < 60; it++) begin
         int snd [N_CELL];
         bit err_mode;
         err_mode = (it % 4 == 3);
         for (int t = 0; t < NT; t++)
            wr(t, LW'($urandom & $urandom & $urandom));
         for (int c = 0; c < N_CELL; c++) begin
            int r;
            r = $urandom % 10;
            snd[c] = (r < 5) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : (err_mode ? 3 : 0);
            if (!err_mode && c == N_CELL-1 && snd[c] == 1) snd[c] = 0;
            if (!err_mode && c == 0 && snd[c] == 2) snd[c] = 0;
         end
         for (int c = 0; c < N_CELL; c++) begin
            int tdn, tup;
            tdn = (c > 0 && snd[c-1] == 1) ? 1 : 0;
            tup = (c < N_CELL-1 && snd[c+1] == 2) ? 1 : 0;
            if (err_mode && ($urandom % 4 == 0)) tdn = 1 - tdn;
            wr(NT + c, cw(int'($urandom % 32), tdn, tup, snd[c]));
         end
         for (int k = 0; k < 8; k++) begin
            drive(N_IN'($urandom));
            // R1 R3 R4 R5 R6 R7 R8 R10 against the model
            check_all("R6");
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
   end

endmodule